// File: doc/BRIEF.md
# CAN-FD Transmitter Delay Compensation

During the fast data phase of a CAN-FD frame, the loop through the transceiver delays the receive line behind the transmit line. That delay can be longer than a whole data bit. This block finds the point in each transmitted bit where the looped-back receive level can be trusted: the secondary sample point. It then samples the receive line there and reports the bit it saw. Everything runs on the system clock. The bit-timing logic outside the block pulses a start input at the beginning of each transmitted bit.

The delay comes from one of two sources. In automatic operation the block counts clock edges from the bit start until the receive level changes away from the level it had at the bit start. That count is the measured delay, held until the next measurement completes. In manual operation a configured delay is used and no measurement is made. A two's complement offset is added to the delay, and the sum gives the position of the sample point in clock cycles after the bit start. Sums of zero or below fire immediately. When compensation is off, no strobe is produced and the reported delay is zero.

Top module: `ssp_delay_comp`

## Requirements
- R1: The mode input is decoded as follows: 2'b00 turns compensation off, 2'b01 selects manual delay, and both 2'b10 and 2'b11 select automatic measurement with identical behaviour.
- R2: While the mode is off, `dly_o` reads 0. This includes the reset state, where `ssp_stb_o` and `ssp_bit_o` are also 0.
- R3: In manual mode `dly_o` equals `manual_dly_i`, and no measurement is made: the stored measured value is unchanged when automatic mode is selected again.
- R4: In automatic mode the measured delay is d. Edge 0 is the clock edge that samples `bit_start_i` high, and d is the index of the first later edge at which `rx_i` differs from its value at edge 0. The result appears on `dly_o` in the cycle after edge d.
- R5: If `rx_i` has not changed by edge 63, the measured delay saturates at 63.
- R6: In automatic mode `dly_o` holds the last measured delay until a later measurement completes.
- R7: The sample position is p = D + O. D is `dly_o` (unsigned, 6 bits) in the cycle `bit_start_i` is high. O is `offset_i`, read as a 7-bit two's complement number (-64..63) in that same cycle. `ssp_stb_o` is high in the cycle after edge p.
- R8: If D + O is zero or negative, p is clamped to 0, so the strobe is high in the cycle right after edge 0.
- R9: Each bit start in a non-off mode yields exactly one strobe cycle.
- R10: `ssp_bit_o` is updated together with the strobe to the `rx_i` level sampled at edge p, and holds that level until the next strobe.
- R11: While the mode is off, `ssp_stb_o` stays low.
- R12: Changes to `offset_i` or `manual_dly_i` after edge 0 do not move the strobe of the bit already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_start_i | input | 1 | One-cycle pulse at the start of a transmitted bit |
| rx_i | input | 1 | Receive line level, looped back from the transceiver |
| mode_i | input | 2 | Compensation mode: 00 off, 01 manual, 1x automatic |
| offset_i | input | 7 | Signed offset added to the delay, in clock cycles |
| manual_dly_i | input | 6 | Delay used in manual mode, in clock cycles |
| dly_o | output | 6 | Delay currently in effect (measured, manual or zero) |
| ssp_stb_o | output | 1 | One-cycle strobe at the secondary sample point |
| ssp_bit_o | output | 1 | Receive level captured at the last strobe |

## Verification
Most internal faults show up as a strobe in the wrong cycle. A miscounting position counter or a wrongly latched target moves the strobe or repeats it, and this appears no later than 128 cycles after the bit start. A bad measurement counter or a bad edge reference puts a wrong value on `dly_o` once the measurement window closes. The fault also reaches the strobe: the next bit places its strobe from that wrong value. A sign or width error in the offset sum appears only for negative or large offsets. For that reason every offset is swept against several delays.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    TDC_OFF    = 2'b00,
    TDC_MAN    = 2'b01,
    TDC_AUTO_A = 2'b10,
    TDC_AUTO_B = 2'b11
  } tdc_mode_e;

  function automatic logic mode_is_auto(tdc_mode_e m);
    return (m == TDC_AUTO_A) || (m == TDC_AUTO_B);
  endfunction
endpackage

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas #(
  parameter int DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rx_i,
  output logic [DLY_W-1:0] dly_o
);
  localparam logic [DLY_W-1:0] DLY_MAX = '1;

  logic [DLY_W-1:0] cnt_q, dly_q;
  logic             run_q, ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dly_q <= '0;
      run_q <= 1'b0;
      ref_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      ref_q <= rx_i;
      cnt_q <= DLY_W'(1);
    end else if (run_q) begin
      if (rx_i != ref_q) begin
        dly_q <= cnt_q;
        run_q <= 1'b0;
      end else if (cnt_q == DLY_MAX) begin
        dly_q <= DLY_MAX;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + DLY_W'(1);
      end
    end
  end

  assign dly_o = dly_q;
endmodule

// File: rtl/tdc_ssp_target.sv
module tdc_ssp_target #(
  parameter int DLY_W = 6,
  parameter int OFF_W = 7,
  parameter int POS_W = 7
) (
  input  logic [DLY_W-1:0] dly_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [POS_W-1:0] pos_o
);
  localparam int SUM_W = POS_W + 1;

  logic signed [SUM_W-1:0] dly_ext, off_ext, sum;

  assign dly_ext = $signed({{(SUM_W-DLY_W){1'b0}}, dly_i});
  assign off_ext = $signed({{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i});
  assign sum     = dly_ext + off_ext;
  // non-positive sums clamp to position 0
  assign pos_o   = sum[SUM_W-1] ? '0 : sum[POS_W-1:0];
endmodule

// File: rtl/tdc_ssp_sched.sv
module tdc_ssp_sched #(
  parameter int POS_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [POS_W-1:0] tgt_i,
  input  logic             rx_i,
  output logic             stb_o,
  output logic             bit_o
);
  logic [POS_W-1:0] pcnt_q, tgt_q;
  logic             armed_q, stb_q, bit_q;
  logic             hit;

  assign hit = armed_q && (pcnt_q == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q  <= '0;
      tgt_q   <= '0;
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
      bit_q   <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
    end else if (start_i) begin
      pcnt_q  <= POS_W'(1);
      tgt_q   <= tgt_i;
      armed_q <= (tgt_i != '0);
      stb_q   <= (tgt_i == '0);
      if (tgt_i == '0) bit_q <= rx_i;
    end else if (hit) begin
      stb_q   <= 1'b1;
      bit_q   <= rx_i;
      armed_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (armed_q) pcnt_q <= pcnt_q + POS_W'(1);
    end
  end

  assign stb_o = stb_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/ssp_delay_comp.sv
module ssp_delay_comp #(
  parameter int DLY_W = 6,
  parameter int OFF_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_start_i,
  input  logic             rx_i,
  input  logic [1:0]       mode_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [DLY_W-1:0] manual_dly_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             ssp_stb_o,
  output logic             ssp_bit_o
);
  import tdc_pkg::*;

  localparam int POS_W = ((DLY_W > OFF_W - 1) ? DLY_W : OFF_W - 1) + 1;

  tdc_mode_e        mode;
  logic             is_auto, is_on;
  logic [DLY_W-1:0] meas_dly, dly_sel;
  logic [POS_W-1:0] tgt;

  assign mode    = tdc_mode_e'(mode_i);
  assign is_auto = mode_is_auto(mode);
  assign is_on   = (mode != TDC_OFF);

  always_comb begin
    unique case (mode)
      TDC_OFF: dly_sel = '0;
      TDC_MAN: dly_sel = manual_dly_i;
      default: dly_sel = meas_dly;
    endcase
  end

  tdc_delay_meas #(.DLY_W(DLY_W)) i_meas (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bit_start_i && is_auto),
    .rx_i    (rx_i),
    .dly_o   (meas_dly)
  );

  tdc_ssp_target #(.DLY_W(DLY_W), .OFF_W(OFF_W), .POS_W(POS_W)) i_target (
    .dly_i (dly_sel),
    .off_i (offset_i),
    .pos_o (tgt)
  );

  tdc_ssp_sched #(.POS_W(POS_W)) i_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (is_on),
    .start_i (bit_start_i),
    .tgt_i   (tgt),
    .rx_i    (rx_i),
    .stb_o   (ssp_stb_o),
    .bit_o   (ssp_bit_o)
  );

  assign dly_o = dly_sel;
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int DLY_W = 6,
  parameter int OFF_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_start_i,
  input logic             rx_i,
  input logic [1:0]       mode_i,
  input logic [OFF_W-1:0] offset_i,
  input logic [DLY_W-1:0] dly_o,
  input logic             ssp_stb_o,
  input logic             ssp_bit_o
);
  localparam int SW = ((DLY_W > OFF_W) ? DLY_W : OFF_W) + 2;

  logic signed [SW-1:0] chk_sum;
  assign chk_sum = $signed({{(SW-DLY_W){1'b0}}, dly_o})
                 + $signed({{(SW-OFF_W){offset_i[OFF_W-1]}}, offset_i});

  AST_OFF_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && $past(mode_i) == 2'b00) |-> !ssp_stb_o); // R11

  AST_STB_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ssp_stb_o && !bit_start_i) |=> !ssp_stb_o); // R9

  AST_CLAMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_start_i && mode_i != 2'b00 && chk_sum <= 0) |=> ssp_stb_o); // R8

  AST_BIT_AT_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ssp_stb_o) |-> (ssp_bit_o == $past(rx_i))); // R10
endmodule

bind ssp_delay_comp tdc_checker #(.DLY_W(DLY_W), .OFF_W(OFF_W)) i_tdc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_start_i (bit_start_i),
  .rx_i        (rx_i),
  .mode_i      (mode_i),
  .offset_i    (offset_i),
  .dly_o       (dly_o),
  .ssp_stb_o   (ssp_stb_o),
  .ssp_bit_o   (ssp_bit_o)
);

// File: tb/test_ssp_delay_comp.sv
module test_ssp_delay_comp;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_start_i = 1'b0;
  logic       rx_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [6:0] offset_i = '0;
  logic [5:0] manual_dly_i = '0;
  logic [5:0] dly_o;
  logic       ssp_stb_o, ssp_bit_o;

  int vecs = 0;
  int errs = 0;
  int exp_meas = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ssp_delay_comp i_ssp_delay_comp (
    .clk_i, .rst_ni, .bit_start_i, .rx_i, .mode_i, .offset_i,
    .manual_dly_i, .dly_o, .ssp_stb_o, .ssp_bit_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // d: edge index at which rx first differs (64 = never within window)
  task automatic run_bit(input logic [1:0] md, input int off, input int man,
                         input int d, input bit scramble);
    int dly_used, p, win, dm, end_man;
    bit exp_stb;
    logic rref;
    @(negedge clk_i);
    mode_i = md;
    offset_i = 7'(off);
    manual_dly_i = 6'(man);
    #1;
    dly_used = (md == 2'b00) ? 0 : (md == 2'b01) ? man : exp_meas;
    if (md == 2'b00)      chk(dly_o == 6'(dly_used), "R2 off delay", int'(dly_o), dly_used);
    else if (md == 2'b01) chk(dly_o == 6'(dly_used), "R3 manual delay", int'(dly_o), dly_used);
    else                  chk(dly_o == 6'(dly_used), "R6 R1 held delay", int'(dly_o), dly_used);
    p = dly_used + off;
    if (p < 0) p = 0;
    dm = (d > 63) ? 63 : d;
    win = ((md[1] && dm > p) ? dm : p) + 2;
    rref = rx_i;
    bit_start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bit_start_i = 1'b0;
    end_man = man;
    if (scramble) begin
      offset_i = ~offset_i;
      manual_dly_i = ~manual_dly_i;
      end_man = 63 - man;
    end
    for (int k = 0; k <= win; k++) begin
      if (k > 0) @(negedge clk_i);
      exp_stb = (md != 2'b00) && (k == p);
      if (md == 2'b00)   chk(ssp_stb_o == 1'b0, "R11 no strobe when off", int'(ssp_stb_o), 0);
      else if (p == 0)   chk(ssp_stb_o == exp_stb, "R8 R9 clamped strobe", int'(ssp_stb_o), int'(exp_stb));
      else if (scramble) chk(ssp_stb_o == exp_stb, "R12 R7 strobe position", int'(ssp_stb_o), int'(exp_stb));
      else               chk(ssp_stb_o == exp_stb, "R7 R9 strobe position", int'(ssp_stb_o), int'(exp_stb));
      if (exp_stb)
        chk(ssp_bit_o == ((k >= d) ? ~rref : rref), "R10 sampled bit",
            int'(ssp_bit_o), int'((k >= d) ? ~rref : rref));
      rx_i = (k + 1 >= d) ? ~rref : rref;
    end
    if (md[1]) begin
      exp_meas = dm;
      if (d > 63) chk(dly_o == 6'(dm), "R5 saturated delay", int'(dly_o), dm);
      else        chk(dly_o == 6'(dm), "R4 R1 measured delay", int'(dly_o), dm);
    end else if (md == 2'b01) begin
      chk(dly_o == 6'(end_man), "R3 manual delay", int'(dly_o), end_man);
    end else begin
      chk(dly_o == 6'd0, "R2 off delay", int'(dly_o), 0);
    end
  endtask

  initial begin
    int offs[5] = '{-64, -3, 0, 5, 63};
    int mans[5] = '{0, 1, 17, 40, 63};
    repeat (3) @(negedge clk_i);
    chk(ssp_stb_o == 1'b0, "R2 reset strobe", int'(ssp_stb_o), 0);
    chk(ssp_bit_o == 1'b0, "R2 reset bit", int'(ssp_bit_o), 0);
    chk(dly_o == 6'd0, "R2 reset delay", int'(dly_o), 0);
    rst_ni = 1'b1;

    run_bit(2'b00, 5, 20, 7, 1'b0);
    run_bit(2'b00, -10, 0, 3, 1'b0);

    for (int mi = 0; mi < 5; mi++)
      for (int off = -64; off <= 63; off++)
        run_bit(2'b01, off, mans[mi], (off & 31) + 1, off[0]);

    for (int d = 1; d <= 64; d++)
      for (int oi = 0; oi < 5; oi++)
        run_bit((oi % 2 == 1) ? 2'b11 : 2'b10, offs[oi], 0, d, oi == 2);

    // manual mode must leave the stored measurement untouched
    run_bit(2'b10, 0, 0, 21, 1'b0);
    run_bit(2'b01, 0, 9, 5, 1'b0);
    run_bit(2'b01, 4, 50, 2, 1'b0);
    @(negedge clk_i);
    mode_i = 2'b11;
    #1;
    chk(dly_o == 6'(exp_meas), "R3 no measurement in manual", int'(dly_o), exp_meas);
    run_bit(2'b10, 0, 0, 12, 1'b0);
    run_bit(2'b00, 0, 0, 4, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule